// File: doc/BRIEF.md
# Low-Voltage Access Lockout Timer

This block sits between a host and a memory array and keeps the array unreachable while the supply is unsafe. An external comparator gives a "supply above threshold" flag. The block passes that flag through a synchronizer. While the flag is false, the block holds an active-low lockout status pin low and forces every strobe toward the array to inactive.

When the synchronized flag turns true, a hold-off counter runs for a parameterised number of clock cycles. The lockout is released only after that count completes. From then on, the host's chip-enable, write-enable and output-enable requests reach the array unchanged. Any drop of the flag, whether during the count or after release, locks the array out again. The drop cuts off any access in flight in the same cycle, and the next rise restarts the count from zero.

Top module: `lowVoltLockout`

## Requirements
- R1: After the asynchronous reset (`rstN` low), `lockoutN` is 0 and `arrayCe`, `arrayWe` and `arrayOe` are all 0.
- R2: While the synchronized supply flag is false, `lockoutN` is 0 and all three array strobes are 0, whatever the host requests.
- R3: `supplyGoodRaw` may rise and then stay high, with its first sampled high value at clock edge 1. `lockoutN` is 0 after edges 1 through HOLD_CYCLES+2 and becomes 1 after edge HOLD_CYCLES+3. This is two synchronizer edges, one edge to start the hold-off, and HOLD_CYCLES edges of counting.
- R4: Once `lockoutN` is 1, it stays 1 for as long as `supplyGoodRaw` stays high.
- R5: When `supplyGoodRaw` falls after release, with its first sampled low value at edge 1, `lockoutN` is still 1 after edge 1 and is 0 after edge 2.
- R6: A low on `supplyGoodRaw` lasting even one sample during the hold-off count restarts the count. The release then follows the R3 timing measured from the new rise.
- R7: After release, the strobes are all active-high: `arrayCe` = `hostCe`, `arrayWe` = `hostCe & hostWe`, and `arrayOe` = `hostCe & hostOe`.
- R8: A write in progress when the supply drops is aborted. `arrayWe` goes to 0 in the same cycle as `lockoutN` falls.
- R9: A one-sample supply glitch after release relocks the array. The full hold-off then has to elapse again, with the R3 timing measured from the recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| supplyGoodRaw | input | 1 | Supply-above-threshold flag from the comparator, not synchronized |
| hostCe | input | 1 | Host chip-enable request, active high |
| hostWe | input | 1 | Host write-enable request, active high |
| hostOe | input | 1 | Host output-enable request, active high |
| lockoutN | output | 1 | Lockout status, low while access is locked |
| arrayCe | output | 1 | Gated chip-enable to the array |
| arrayWe | output | 1 | Gated write-enable to the array |
| arrayOe | output | 1 | Gated output-enable to the array |

## Verification
The interesting collision is a host write that is active at the moment the synchronized supply flag falls. Here the abort path and the lockout path act in the same cycle. The bench holds `hostCe` and `hostWe` high across a supply fall and samples both outputs after each edge. `arrayWe` and `lockoutN` must stay 1 after the first edge and both must read 0 after the second. A second collision is a supply dip that lands in the middle of the hold-off count. For that case the bench checks that no early release appears at the point where the original count would have ended.

// File: rtl/lowVoltPkg.sv
package lowVoltPkg;

  typedef enum logic [1:0] {
    ST_LOCKED = 2'd0,
    ST_HOLD   = 2'd1,
    ST_READY  = 2'd2
  } lvState_t;

  typedef struct packed {
    logic clear;
    logic inc;
  } cntCmd_t;

endpackage

// File: rtl/lowVoltDatapath.sv
module lowVoltDatapath
  import lowVoltPkg::*;
#(
  parameter int HOLD_CYCLES = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    supplyGoodRaw,
  input  cntCmd_t cmd,
  output logic    supplyGood,
  output logic    cntDone
);

  localparam int CNT_W = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_CYCLES - 1);

  logic [SYNC_STAGES-1:0] syncChain;
  logic [CNT_W-1:0]       holdCnt;

  // supply flag synchronizer, stage count chosen by parameter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain[0] <= 1'b0;
    else       syncChain[0] <= supplyGoodRaw;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncChain[s] <= 1'b0;
      else       syncChain[s] <= syncChain[s-1];
    end
  end

  assign supplyGood = syncChain[SYNC_STAGES-1];

  // hold-off counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          holdCnt <= '0;
    else if (cmd.clear) holdCnt <= '0;
    else if (cmd.inc)   holdCnt <= holdCnt + 1'b1;
  end

  assign cntDone = (holdCnt == CNT_LAST);

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    holdCnt <= CNT_LAST);

  assert_cnt_restart_R6: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clear |=> (holdCnt == '0));

endmodule

// File: rtl/lowVoltCtrl.sv
module lowVoltCtrl
  import lowVoltPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    supplyGood,
  input  logic    cntDone,
  output cntCmd_t cmd,
  output logic    ready
);

  lvState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_LOCKED;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    cmd       = '0;
    unique case (state)
      ST_LOCKED: begin
        if (supplyGood) begin
          nextState = ST_HOLD;
          cmd.clear = 1'b1;
        end
      end
      ST_HOLD: begin
        if (!supplyGood)  nextState = ST_LOCKED;
        else if (cntDone) nextState = ST_READY;
        else              cmd.inc   = 1'b1;
      end
      ST_READY: begin
        if (!supplyGood) nextState = ST_LOCKED;
      end
      default: nextState = ST_LOCKED;
    endcase
  end

  assign ready = (state == ST_READY);

  assert_release_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD && supplyGood && cntDone) |=> (state == ST_READY));

  assert_no_early_release_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD && !cntDone) |=> (state != ST_READY));

  assert_dip_restart_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_LOCKED && !supplyGood) |=> (state == ST_LOCKED));

endmodule

// File: rtl/lowVoltLockout.sv
module lowVoltLockout
  import lowVoltPkg::*;
#(
  parameter int HOLD_CYCLES = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic supplyGoodRaw,
  input  logic hostCe,
  input  logic hostWe,
  input  logic hostOe,
  output logic lockoutN,
  output logic arrayCe,
  output logic arrayWe,
  output logic arrayOe
);

  cntCmd_t cntCmd;
  logic    supplyGood;
  logic    cntDone;
  logic    ready;
  logic    accessEn;

  lowVoltDatapath #(
    .HOLD_CYCLES(HOLD_CYCLES),
    .SYNC_STAGES(SYNC_STAGES)
  ) datapath_i (
    .clk          (clk),
    .rstN         (rstN),
    .supplyGoodRaw(supplyGoodRaw),
    .cmd          (cntCmd),
    .supplyGood   (supplyGood),
    .cntDone      (cntDone)
  );

  lowVoltCtrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .supplyGood(supplyGood),
    .cntDone   (cntDone),
    .cmd       (cntCmd),
    .ready     (ready)
  );

  // a falling supply flag cuts access in the same cycle it is seen
  assign accessEn = ready & supplyGood;
  assign lockoutN = accessEn;
  assign arrayCe  = hostCe & accessEn;
  assign arrayWe  = hostCe & hostWe & accessEn;
  assign arrayOe  = hostCe & hostOe & accessEn;

  assert_gate_R2: assert property (@(posedge clk) disable iff (!rstN)
    !supplyGood |-> !(arrayCe || arrayWe || arrayOe) && !lockoutN);

  assert_hold_high_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lockoutN) |-> !supplyGood);

  assert_write_abort_R8: assert property (@(posedge clk) disable iff (!rstN)
    !lockoutN |-> !arrayWe);

  always_comb begin
    if (rstN) assert_pass_R7: assert (!lockoutN || (arrayCe == hostCe));
  end

endmodule

// File: tb/lowVoltLockout_tb_top.sv
module lowVoltLockout_tb_top;

  localparam int HOLD = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supplyGoodRaw = 1'b0;
  logic hostCe = 1'b0;
  logic hostWe = 1'b0;
  logic hostOe = 1'b0;
  logic lockoutN, arrayCe, arrayWe, arrayOe;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  lowVoltLockout #(.HOLD_CYCLES(HOLD)) dut_i (
    .clk(clk), .rstN(rstN), .supplyGoodRaw(supplyGoodRaw),
    .hostCe(hostCe), .hostWe(hostWe), .hostOe(hostOe),
    .lockoutN(lockoutN), .arrayCe(arrayCe), .arrayWe(arrayWe), .arrayOe(arrayOe)
  );

  task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] outs();
    return {lockoutN, arrayCe, arrayWe, arrayOe};
  endfunction

  // raw flag rises at a negedge, then follow the release timing
  task automatic riseAndRelease(input string tag);
    supplyGoodRaw = 1'b1;
    hostCe = 1'b1; hostWe = 1'b1; hostOe = 1'b1;
    for (int i = 1; i <= HOLD + 2; i++) begin
      @(negedge clk);
      check(outs(), 4'b0000, tag);
    end
    @(negedge clk);
    check(outs(), 4'b1111, tag);
  endtask

  task automatic testReset();
    hostCe = 1'b1; hostWe = 1'b1; hostOe = 1'b1;
    #1;
    check(outs(), 4'b0000, "R1 reset state");
    rstN = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(outs(), 4'b0000, "R2 supply low blocks access");
    end
  endtask

  task automatic testPowerUp();
    riseAndRelease("R3 power-up hold-off");
  endtask

  task automatic testPassThrough();
    for (int p = 0; p < 8; p++) begin
      hostCe = p[0]; hostWe = p[1]; hostOe = p[2];
      #1;
      check(outs(), {1'b1, p[0], p[0] & p[1], p[0] & p[2]}, "R7 strobe pass-through");
      @(negedge clk);
    end
  endtask

  task automatic testSteady();
    hostCe = 1'b0; hostWe = 1'b0; hostOe = 1'b0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      check({3'b000, lockoutN}, 4'b0001, "R4 stays released");
    end
  endtask

  task automatic testDropDuringWrite();
    hostCe = 1'b1; hostWe = 1'b1; hostOe = 1'b0;
    supplyGoodRaw = 1'b0;
    @(negedge clk);
    check({2'b00, lockoutN, arrayWe}, 4'b0011, "R5 one edge after fall still released");
    @(negedge clk);
    check({2'b00, lockoutN, arrayWe}, 4'b0000, "R8 write aborted with lockout");
    check(outs(), 4'b0000, "R5 lockout after two edges");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(outs(), 4'b0000, "R2 supply low after drop");
    end
  endtask

  task automatic testDipDuringHold();
    supplyGoodRaw = 1'b1;
    for (int i = 0; i < 10; i++) @(negedge clk);
    supplyGoodRaw = 1'b0;
    @(negedge clk);
    riseAndRelease("R6 dip restarts hold-off");
  endtask

  task automatic testGlitchAfterRelease();
    supplyGoodRaw = 1'b0;
    @(negedge clk);
    riseAndRelease("R9 glitch after release relocks");
  endtask

  initial begin
    @(negedge clk);
    testReset();
    testPowerUp();
    testPassThrough();
    testSteady();
    testDropDuringWrite();
    testDipDuringHold();
    testGlitchAfterRelease();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule